// File: doc/BRIEF.md
# Double-Buffered Four-Channel Converter Register Controller

This block holds the digital state behind four converter channels and executes already-decoded 24-bit commands on them. Each command arrives as a one-cycle strobe carrying a 4-bit opcode, a 4-bit channel selector and a 16-bit code. Every channel keeps a staging register and a live register. A code can be staged without touching the output, moved to the output later, or staged and moved in one step. One opcode stages a code on one channel and then moves every channel's staged code to its output at once, so all outputs change together.

Channels can be put to sleep individually. A sleeping channel keeps both of its registers. Any command that moves a code to a sleeping channel's output also wakes it. After a wake, the channel's ready flag stays low for a settling window. The window is longer when every channel was asleep before the command, because the shared bias circuitry must then restart. An asynchronous, level-sensitive clear forces both registers of every channel to the power-on code. The power-on code is zero scale or midscale, chosen by a parameter.

Top module: `quad_chan_regctl`

## Requirements
- R1: After reset every staging and live register holds the power-on code: 0x0000 when MID_RESET=0, or 0x8000 when MID_RESET=1 at 16 bits. All channels are awake and all ready flags are high.
- R2: Opcode 0x0 loads the code into the staging register of the selected channel. The live outputs do not change.
- R3: Opcode 0x1 copies the staging register of the selected channel to its live register and wakes that channel.
- R4: Opcode 0x3 loads the code and copies it to the live register of the selected channel in the same cycle. Other channels keep their values.
- R5: Opcode 0x2 loads the code into the staging register of the selected channel. It then copies the staging register of every channel to its live register, using the new code for the selected channel, and wakes all channels.
- R6: Selector values 0x0 to 0x3 pick channels 0 to 3. Selector 0xF applies the command to every channel.
- R7: Opcode 0x4 puts the selected channels to sleep and drops their ready flags. The code field is ignored, and both the staging and the live registers keep their contents.
- R8: A sleeping channel that is woken while at least one other channel is awake keeps its ready flag low for CLK_MHZ*SHORT_US cycles (1250 with the defaults).
- R9: A channel woken when all four channels were asleep keeps its ready flag low for CLK_MHZ*LONG_US cycles (3000 with the defaults).
- R10: While clr_n is low, every staging and live register holds the power-on code, asynchronously to the clock. Sleep state is not changed.
- R11: Opcode 0xF, opcodes 0x5 to 0xE, and selector values 0x4 to 0xE change nothing.
- R12: Outputs change on the clock edge that samples cmd_vld. Live codes are packed with channel 0 in bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| clr_n | input | 1 | Asynchronous level clear of the code registers, active low |
| cmd_vld | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Opcode |
| cmd_sel | input | 4 | Channel selector |
| cmd_code | input | 16 | Code field |
| live_code | output | 64 | Live codes, channel 0 in the lowest bits |
| chan_sleep | output | 4 | Sleep flag per channel |
| chan_ready | output | 4 | Ready flag per channel |

## Verification
Directed sequences separate staging from the live output. A code is staged, shown to be invisible, then moved to the output. A sleep command carrying a different code is followed by a wake, which shows the staged value survived. The settling window is measured in cycles, once with a neighbour still awake and once after every channel slept, which tells the short window from the long one. The clear is asserted mid-cycle to show it acts without a clock edge. A fixed-seed random mix of legal, reserved and broadcast commands is then compared every cycle against a behavioural model, which catches wrong channel selection and wrong counter reloads.

// File: rtl/qcr_pkg.sv
package qcr_pkg;
   typedef enum logic [3:0] {
      OP_STAGE      = 4'h0,
      OP_COMMIT     = 4'h1,
      OP_STAGE_ALL  = 4'h2,
      OP_STAGE_COMM = 4'h3,
      OP_SLEEP      = 4'h4,
      OP_IDLE       = 4'hF
   } qcr_op_e;

   localparam logic [3:0] SEL_EVERY = 4'hF;
endpackage

// File: rtl/qcr_decode.sv
module qcr_decode
   import qcr_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic           vld,
   input  logic [3:0]     op,
   input  logic [3:0]     sel,
   output logic [NCH-1:0] wr_v,
   output logic [NCH-1:0] upd_v,
   output logic [NCH-1:0] pd_v,
   output logic           legal
);
   logic [NCH-1:0] hit;
   logic           sel_ok;
   logic           op_ok;

   always_comb begin
      sel_ok = (sel == SEL_EVERY) || (int'(sel) < NCH);
      op_ok  = (op == OP_STAGE) || (op == OP_COMMIT) || (op == OP_STAGE_ALL)
            || (op == OP_STAGE_COMM) || (op == OP_SLEEP);
      legal  = vld && sel_ok && op_ok;
   end

   for (genvar i = 0; i < NCH; i++) begin : g_hit
      assign hit[i] = (sel == SEL_EVERY) || (int'(sel) == i);
   end

   always_comb begin
      wr_v  = '0;
      upd_v = '0;
      pd_v  = '0;
      if (legal) begin
         unique case (op)
            OP_STAGE:      wr_v = hit;
            OP_COMMIT:     upd_v = hit;
            OP_STAGE_ALL:  begin wr_v = hit; upd_v = '1; end
            OP_STAGE_COMM: begin wr_v = hit; upd_v = hit; end
            OP_SLEEP:      pd_v = hit;
            default:       ;
         endcase
      end
   end
endmodule

// File: rtl/qcr_slice.sv
module qcr_slice #(
   parameter int DW        = 16,
   parameter bit MID_RESET = 1'b0,
   parameter int CW        = 12,
   parameter int SHORT_CYC = 1250,
   parameter int LONG_CYC  = 3000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_n,
   input  logic          wr_en,
   input  logic          upd_en,
   input  logic          pd_en,
   input  logic          all_down,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] act_o,
   output logic          pdn_o,
   output logic          rdy_o
);
   logic [DW-1:0] init_code;
   logic [DW-1:0] stage_q, act_q, stage_nx;
   logic          pdn_q;
   logic [CW-1:0] wait_q;

   if (MID_RESET) begin : g_mid
      assign init_code = {1'b1, {(DW-1){1'b0}}};
   end else begin : g_zero
      assign init_code = '0;
   end

   assign stage_nx = wr_en ? wdata : stage_q;

   always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
      if (!rst_n || !clr_n) begin
         stage_q <= init_code;
         act_q   <= init_code;
      end else begin
         stage_q <= stage_nx;
         if (upd_en) act_q <= stage_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pdn_q  <= 1'b0;
         wait_q <= '0;
      end else if (pd_en) begin
         pdn_q  <= 1'b1;
         wait_q <= '0;
      end else if (upd_en && pdn_q) begin
         pdn_q  <= 1'b0;
         wait_q <= all_down ? CW'(LONG_CYC) : CW'(SHORT_CYC);
      end else if (wait_q != '0) begin
         wait_q <= wait_q - 1'b1;
      end
   end

   assign act_o = act_q;
   assign pdn_o = pdn_q;
   assign rdy_o = !pdn_q && (wait_q == '0);

   p_sleep_keeps_code_r7: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      pd_en |=> $stable(act_q));
   p_stage_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      (wr_en && !upd_en) |=> $stable(act_q));
   p_update_wakes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !pd_en) |=> !pdn_q);
   p_wake_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pdn_q) |-> !rdy_o);
endmodule

// File: rtl/quad_chan_regctl.sv
module quad_chan_regctl
   import qcr_pkg::*;
#(
   parameter int NCH       = 4,
   parameter int DW        = 16,
   parameter bit MID_RESET = 1'b0,
   parameter int CLK_MHZ   = 250,
   parameter int SHORT_US  = 5,
   parameter int LONG_US   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_n,
   input  logic              cmd_vld,
   input  logic [3:0]        cmd_op,
   input  logic [3:0]        cmd_sel,
   input  logic [DW-1:0]     cmd_code,
   output logic [NCH*DW-1:0] live_code,
   output logic [NCH-1:0]    chan_sleep,
   output logic [NCH-1:0]    chan_ready
);
   localparam int SHORT_CYC = CLK_MHZ * SHORT_US;
   localparam int LONG_CYC  = CLK_MHZ * LONG_US;
   localparam int CW        = $clog2(LONG_CYC + 1);
   localparam logic [DW-1:0] INIT = MID_RESET ? {1'b1, {(DW-1){1'b0}}} : '0;

   if (NCH < 1 || NCH > 15) begin : g_bad_nch
      $error("NCH must lie in 1..15");
   end
   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end
   if (SHORT_CYC < 1 || LONG_CYC < SHORT_CYC) begin : g_bad_wait
      $error("wake windows must be positive and ordered");
   end

   logic [NCH-1:0] wr_v, upd_v, pd_v;
   logic           legal;

   qcr_decode #(.NCH(NCH)) u_dec (
      .vld(cmd_vld), .op(cmd_op), .sel(cmd_sel),
      .wr_v(wr_v), .upd_v(upd_v), .pd_v(pd_v), .legal(legal)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      qcr_slice #(
         .DW(DW), .MID_RESET(MID_RESET), .CW(CW),
         .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)
      ) u_slice (
         .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
         .wr_en(wr_v[i]), .upd_en(upd_v[i]), .pd_en(pd_v[i]),
         .all_down(&chan_sleep), .wdata(cmd_code),
         .act_o(live_code[i*DW +: DW]), .pdn_o(chan_sleep[i]), .rdy_o(chan_ready[i])
      );
   end

   p_reserved_idle_r11: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      (cmd_vld && !legal) |=> ($stable(live_code) && $stable(chan_sleep)));
   p_clear_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> (live_code == {NCH{INIT}}));
   p_sleep_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_op == 4'h4 && cmd_sel == 4'hF) |=> (&chan_sleep && chan_ready == '0));
endmodule

// File: tb/quad_chan_regctl_bench.sv
`timescale 1ns/1ps
module quad_chan_regctl_bench;
   localparam int NCH = 4, DW = 16;
   localparam int SHORTC = 1250, LONGC = 3000;
   localparam logic [15:0] INIT = 16'h8000;

   logic clk = 0, rst_n = 0, clr_n = 1, cmd_vld = 0;
   logic [3:0] cmd_op = 0, cmd_sel = 0;
   logic [15:0] cmd_code = 0;
   logic [63:0] live_code;
   logic [3:0] chan_sleep, chan_ready;

   int checks = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   quad_chan_regctl #(.MID_RESET(1'b1)) u_quad_chan_regctl (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cmd_vld(cmd_vld),
      .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_code(cmd_code),
      .live_code(live_code), .chan_sleep(chan_sleep), .chan_ready(chan_ready)
   );

   // behavioural model built from the requirements
   logic [15:0] m_in [4];
   logic [15:0] m_act [4];
   logic [3:0]  m_pdn;
   int          m_cnt [4];

   function automatic bit legal_f(logic [3:0] op, logic [3:0] sel);
      return (op <= 4'h4) && (sel == 4'hF || sel < 4'h4);
   endfunction

   function automatic bit hit_f(logic [3:0] sel, int i);
      return (sel == 4'hF) || (int'(sel) == i);
   endfunction

   always @(posedge clk or negedge rst_n or negedge clr_n) begin
      if (!rst_n || !clr_n) begin
         for (int i = 0; i < 4; i++) begin m_in[i] = INIT; m_act[i] = INIT; end
      end else if (cmd_vld && legal_f(cmd_op, cmd_sel)) begin
         for (int i = 0; i < 4; i++) begin
            if (hit_f(cmd_sel, i) && (cmd_op == 0 || cmd_op == 2 || cmd_op == 3)) m_in[i] = cmd_code;
            if ((hit_f(cmd_sel, i) && (cmd_op == 1 || cmd_op == 3)) || cmd_op == 2) m_act[i] = m_in[i];
         end
      end
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pdn = 0;
         for (int i = 0; i < 4; i++) m_cnt[i] = 0;
      end else begin
         automatic bit alld = &m_pdn;
         automatic bit ok = cmd_vld && legal_f(cmd_op, cmd_sel);
         for (int i = 0; i < 4; i++) begin
            automatic bit upd = ok && ((hit_f(cmd_sel, i) && (cmd_op == 1 || cmd_op == 3)) || cmd_op == 2);
            automatic bit pd  = ok && hit_f(cmd_sel, i) && cmd_op == 4;
            if (pd) begin m_pdn[i] = 1; m_cnt[i] = 0; end
            else if (upd && m_pdn[i]) begin m_pdn[i] = 0; m_cnt[i] = alld ? LONGC : SHORTC; end
            else if (m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
         end
      end
   end

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(string req);
      logic [63:0] ec;
      logic [3:0] er;
      for (int i = 0; i < 4; i++) begin
         ec[i*16 +: 16] = m_act[i];
         er[i] = !m_pdn[i] && m_cnt[i] == 0;
      end
      chk({req, " live"}, live_code, ec);
      chk({req, " sleep"}, {60'd0, chan_sleep}, {60'd0, m_pdn});
      chk({req, " ready"}, {60'd0, chan_ready}, {60'd0, er});
   endtask

   task automatic do_cmd(logic [3:0] op, logic [3:0] sel, logic [15:0] code);
      @(negedge clk);
      cmd_vld = 1; cmd_op = op; cmd_sel = sel; cmd_code = code;
      @(negedge clk);
      cmd_vld = 0;
   endtask

   task automatic ready_low(int ch, output int n);
      n = 0;
      while (chan_ready[ch] == 0 && n < 5000) begin n++; @(negedge clk); end
   endtask

   initial begin
      #800000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      logic [3:0] ops [8] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'hF, 4'h5, 4'h9};
      logic [3:0] sels [6] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'hF, 4'h7};
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 live", live_code, {4{INIT}});
      chk("R1 ready", {60'd0, chan_ready}, 64'hF);
      check_all("R1");
      // R2 staging hidden, R3 commit
      do_cmd(4'h0, 4'h1, 16'h1234);
      chk("R2 hidden", live_code, {4{INIT}});
      do_cmd(4'h1, 4'h1, 16'h0000);
      chk("R3 commit", live_code[31:16], 64'h1234);
      // R4 stage and commit one channel, R12 packing
      do_cmd(4'h3, 4'h2, 16'hABCD);
      chk("R4 R12 one channel", live_code, {INIT, 16'hABCD, 16'h1234, INIT});
      // R6 broadcast selector
      do_cmd(4'h3, 4'hF, 16'h5555);
      chk("R6 broadcast", live_code, {4{16'h5555}});
      // R5 stage then commit all
      do_cmd(4'h0, 4'h0, 16'h1111);
      do_cmd(4'h0, 4'h3, 16'h3333);
      do_cmd(4'h2, 4'h1, 16'h2222);
      chk("R5 commit all", live_code, {16'h3333, 16'h5555, 16'h2222, 16'h1111});
      // R7 sleep ignores code
      do_cmd(4'h4, 4'h2, 16'hFFFF);
      chk("R7 sleep flags", {56'd0, chan_sleep, chan_ready}, {56'd0, 4'b0100, 4'b1011});
      chk("R7 codes kept", live_code, {16'h3333, 16'h5555, 16'h2222, 16'h1111});
      // R8 short window, staging preserved
      do_cmd(4'h1, 4'h2, 16'h0000);
      chk("R7 staged kept", live_code[47:32], 64'h5555);
      ready_low(2, n);
      chk("R8 short window", n, SHORTC);
      // R9 long window after all asleep
      do_cmd(4'h4, 4'hF, 16'h0000);
      check_all("R9 all asleep");
      do_cmd(4'h1, 4'h0, 16'h0000);
      ready_low(0, n);
      chk("R9 long window", n, LONGC);
      do_cmd(4'h1, 4'h1, 16'h0000);
      ready_low(1, n);
      chk("R8 second wake short", n, SHORTC);
      check_all("R8 after");
      // R11 reserved codes
      do_cmd(4'h5, 4'h0, 16'hDEAD);
      do_cmd(4'h3, 4'h4, 16'hDEAD);
      do_cmd(4'hF, 4'hF, 16'hDEAD);
      do_cmd(4'hE, 4'hF, 16'hDEAD);
      chk("R11 no change", live_code, {16'h3333, 16'h5555, 16'h2222, 16'h1111});
      check_all("R11");
      // R10 asynchronous clear mid-cycle
      @(negedge clk); #1;
      clr_n = 0; #0.5;
      chk("R10 async clear", live_code, {4{INIT}});
      chk("R10 sleep kept", {60'd0, chan_sleep}, 64'b1100);
      repeat (3) @(negedge clk);
      chk("R10 held", live_code, {4{INIT}});
      clr_n = 1;
      do_cmd(4'h1, 4'h3, 16'h0000);
      chk("R10 staging cleared", live_code[63:48], {48'd0, INIT});
      check_all("R10 after");
      repeat (SHORTC + 2) @(negedge clk);
      // random mix against the model
      for (int k = 0; k < 300; k++) begin
         do_cmd(ops[$urandom % 8], sels[$urandom % 6], 16'($urandom));
         check_all("R12 random");
         repeat ($urandom % 4) @(negedge clk);
         check_all("R12 random idle");
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule